// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

A single down-counting timer channel that makes a pulse-width-modulated level and a zero-count interrupt. The counter advances only on a timer clock enable (`tick_i`) from a shared divider, so one clock domain serves several channels running at different rates. Period and duty values are written into shadow buffers. The live counter and the active compare register take those values only at defined points: when the timer starts, when it wraps at zero in auto-reload mode, or on an explicit update command while it is stopped. A period or duty change made while the timer runs therefore takes effect at a period boundary, with no glitch.

A cycle in which a tick finds the counter at zero ends the period. The interrupt then pulses for one clock. The channel either reloads (auto-reload mode) or stops (one-shot mode). Clearing the enable stops the counter where it stands, and no reload follows. The output is low from a load until the counter reaches the active compare value, then high through zero. An invert bit flips the pin level.

Software reaches the channel through a one-cycle write port with three addresses: period buffer, duty buffer and control. Writes to the unused fourth address are ignored.

Top module: `pwm_chan`

## Requirements
- R1: The counter is CNT_W bits wide (16 by default) and counts down. While running, it decrements by one on each clock with `tick_i` high, and it holds its value in every clock with `tick_i` low.
- R2: Write addresses: 0 is the period buffer, 1 is the duty buffer, 2 is control. Control bits are bit0 enable, bit1 update, bit2 auto-reload and bit3 invert. A control write with bit0 set while the timer is stopped loads the counter from the period buffer and the compare register from the duty buffer, and starts the timer. Both take effect at the write's clock edge.
- R3: Writes to the period or duty buffer while the timer runs change neither the live count nor the active compare value of the current period.
- R4: When a tick finds the running counter at zero, `irq_o` is high for exactly the next clock cycle. It is never high otherwise.
- R5: In auto-reload mode, a tick at zero reloads the counter and the compare register from the buffers, so the period is N+1 ticks for a period buffer value N.
- R6: A control write with bit0 clear stops the timer at its present count. Later ticks neither count nor reload, and no interrupt is raised. A later start reloads from the period buffer.
- R7: The level is high exactly while the count is at or below the active compare value C, provided C does not exceed the loaded period N. If C is greater than N, the level stays low for the whole period.
- R8: In one-shot mode (bit2 clear), the tick at zero raises the interrupt and then stops the timer. The counter stays at zero and the level returns low.
- R9: A control write with bit1 set while the timer is stopped loads both active registers from the buffers without starting. While the timer runs, the update bit has no effect.
- R10: With bit3 set, `pwm_o` is the inverse of the level described in R7 and R8. Changing the bit takes effect at the write's edge.
- R11: After reset the timer is stopped, the count is 0, `pwm_o` is low and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer clock enable from the shared divider |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | CNT_W | Write data |
| pwm_o | output | 1 | Modulated output level, after optional inversion |
| irq_o | output | 1 | One-cycle pulse after the zero tick |
| cnt_o | output | CNT_W | Live counter value |
| run_o | output | 1 | Timer running |

## Verification
The assertions check on every cycle that the counter holds without a tick or when stopped, and that it steps by exactly one on a tick. They also check the wrap or stop taken at zero, that the compare register changes only at a load or a wrap, that the interrupt is always preceded by a zero tick, and that a high level never coexists with a count above the compare value. Several behaviours are visible only in the bench's scenarios: the duty and period over whole sweeps of period and compare values, the deferral of buffer writes to the next boundary, the absence of a reload after a stop, the one-shot end and the ignored update while running.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_UPD  = 1;
  localparam int unsigned CTRL_AUTO = 2;
  localparam int unsigned CTRL_INV  = 3;
  localparam int unsigned ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PERIOD = 2'd0,
    REG_DUTY   = 2'd1,
    REG_CTRL   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic upd;
  } cmd_t;
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] period_buf_o,
  output logic [CNT_W-1:0] duty_buf_o,
  output logic             auto_o,
  output logic             inv_o,
  output cmd_t             cmd_o
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && (wr_addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_buf_o <= '0;
      duty_buf_o   <= '0;
      auto_o       <= 1'b0;
      inv_o        <= 1'b0;
    end else if (wr_en_i) begin
      case (reg_sel_e'(wr_addr_i))
        REG_PERIOD: period_buf_o <= wr_data_i;
        REG_DUTY:   duty_buf_o   <= wr_data_i;
        REG_CTRL: begin
          auto_o <= wr_data_i[CTRL_AUTO];
          inv_o  <= wr_data_i[CTRL_INV];
        end
        default: ;
      endcase
    end
  end

  // enable bit is a command, not a stored flag: run state lives in the counter
  always_comb begin
    cmd_o.start = ctrl_wr &&  wr_data_i[CTRL_EN];
    cmd_o.stop  = ctrl_wr && !wr_data_i[CTRL_EN];
    cmd_o.upd   = ctrl_wr &&  wr_data_i[CTRL_UPD];
  end

  p_period_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_addr_i == REG_PERIOD) |=> period_buf_o == $past(wr_data_i));
  p_duty_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_addr_i == REG_DUTY) |=> duty_buf_o == $past(wr_data_i));
endmodule

// File: rtl/pwm_chan_cnt.sv
module pwm_chan_cnt
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_buf_i,
  input  logic             auto_i,
  input  cmd_t             cmd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             load_o,
  output logic             wrap_o,
  output logic             step_o,
  output logic             end_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q, irq_q;
  logic             count_en, at_zero;

  assign at_zero  = (cnt_q == '0);
  // a stop written in the same cycle wins over the tick
  assign count_en = run_q && tick_i && !cmd_i.stop;
  assign load_o   = (cmd_i.start || cmd_i.upd) && !run_q;
  assign wrap_o   = count_en && at_zero && auto_i;
  assign end_o    = count_en && at_zero && !auto_i;
  assign step_o   = count_en && !at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_o || wrap_o) begin
      cnt_q <= period_buf_i;
    end else if (step_o) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (cmd_i.stop)       run_q <= 1'b0;
      else if (cmd_i.start) run_q <= 1'b1;
      else if (end_o)       run_q <= 1'b0;
      irq_q <= count_en && at_zero;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
  assign irq_o = irq_q;

  p_hold_no_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !load_o |=> $stable(cnt_q));
  p_step_one_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && tick_i && !cmd_i.stop && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);
  p_irq_after_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(tick_i) && ($past(cnt_q) == '0) && $past(run_q));
  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && tick_i && !cmd_i.stop && (cnt_q == '0) && auto_i
      |=> run_q && (cnt_q == $past(period_buf_i)));
  p_stopped_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !load_o |=> $stable(cnt_q));
  p_oneshot_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && tick_i && !cmd_i.stop && (cnt_q == '0) && !auto_i
      |=> !run_q && (cnt_q == '0));
endmodule

// File: rtl/pwm_chan_cmp.sv
module pwm_chan_cmp #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             wrap_i,
  input  logic             step_i,
  input  logic             end_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] period_buf_i,
  input  logic [CNT_W-1:0] duty_buf_i,
  input  logic             inv_i,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cmp_q;
  logic             lvl_q;

  // compare register moves only with the counter reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      lvl_q <= 1'b0;
    end else if (load_i || wrap_i) begin
      cmp_q <= duty_buf_i;
      lvl_q <= (period_buf_i == duty_buf_i);
    end else if (end_i) begin
      lvl_q <= 1'b0;
    end else if (step_i && ((cnt_i - ONE) == cmp_q)) begin
      lvl_q <= 1'b1;
    end
  end

  assign pwm_o = lvl_q ^ inv_i;

  p_cmp_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !wrap_i |=> $stable(cmp_q));
  p_level_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q |-> cnt_i <= cmp_q);
  p_oneshot_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |=> !lvl_q);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);
  logic [CNT_W-1:0] period_buf, duty_buf;
  logic             auto_en, inv_en;
  cmd_t             cmd;
  logic             load, wrap, step, oneshot_end;

  pwm_chan_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .period_buf_o (period_buf),
    .duty_buf_o   (duty_buf),
    .auto_o       (auto_en),
    .inv_o        (inv_en),
    .cmd_o        (cmd)
  );

  pwm_chan_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .period_buf_i (period_buf),
    .auto_i       (auto_en),
    .cmd_i        (cmd),
    .cnt_o        (cnt_o),
    .run_o        (run_o),
    .load_o       (load),
    .wrap_o       (wrap),
    .step_o       (step),
    .end_o        (oneshot_end),
    .irq_o        (irq_o)
  );

  pwm_chan_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .wrap_i       (wrap),
    .step_i       (step),
    .end_i        (oneshot_end),
    .cnt_i        (cnt_o),
    .period_buf_i (period_buf),
    .duty_buf_i   (duty_buf),
    .inv_i        (inv_en),
    .pwm_o        (pwm_o)
  );

  p_irq_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !auto_en |=> !irq_o);
endmodule

// File: tb/pwm_chan_test.sv
`timescale 1ns/1ps
module pwm_chan_test;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             pwm, irq, run;
  logic [CNT_W-1:0] cnt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pwm_chan #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pwm_o(pwm), .irq_o(irq), .cnt_o(cnt), .run_o(run)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [CNT_W-1:0] ctrl(input bit en, input bit upd, input bit au, input bit inv);
    return CNT_W'({inv, au, upd, en});
  endfunction

  task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int expc, expl;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 cnt", int'(cnt), 0);
    chk("R11 pwm", int'(pwm), 0);
    chk("R11 irq", int'(irq), 0);
    chk("R11 run", int'(run), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: period N, compare C, both output polarities, auto-reload
    for (int inv = 0; inv < 2; inv++) begin
      for (int n = 0; n < 6; n++) begin
        for (int c = 0; c < 7; c++) begin
          wr(2'd0, CNT_W'(n));
          wr(2'd1, CNT_W'(c));
          wr(2'd2, ctrl(1, 0, 1, inv[0]));
          chk("R2 start cnt", int'(cnt), n);
          chk("R2 start run", int'(run), 1);
          for (int k = 0; k <= 2 * (n + 1) + 1; k++) begin
            if (k > 0) begin
              tick = 1'b1;
              @(negedge clk);
            end
            expc = n - (k % (n + 1));
            expl = ((c <= n) && (expc <= c)) ? 1 : 0;
            chk("R5 cnt", int'(cnt), expc);
            chk("R4 irq", int'(irq), (k > 0 && (k % (n + 1)) == 0) ? 1 : 0);
            chk("R7 R10 pwm", int'(pwm), expl ^ inv);
          end
          tick = 1'b0;
          wr(2'd2, ctrl(0, 0, 1, inv[0]));
        end
      end
    end

    // R1: ticks gate counting
    wr(2'd0, 16'd10);
    wr(2'd1, 16'd3);
    wr(2'd2, ctrl(1, 0, 1, 0));
    idle(4);
    chk("R1 hold without tick", int'(cnt), 10);
    for (int i = 0; i < 6; i++) begin
      tick = i[0] ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
    chk("R1 three ticks", int'(cnt), 7);

    // R3: buffer writes while running are deferred
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd0);
    chk("R3 cnt kept", int'(cnt), 7);
    chk("R3 pwm kept", int'(pwm), 0);
    ticks(4);
    chk("R3 old compare", int'(cnt), 3);
    chk("R3 old compare pwm", int'(pwm), 1);
    ticks(3);
    chk("R3 old period end", int'(cnt), 0);
    ticks(1);
    chk("R3 R4 irq", int'(irq), 1);
    chk("R3 R5 new period", int'(cnt), 2);
    chk("R3 new compare pwm", int'(pwm), 0);
    ticks(2);
    chk("R3 new compare hit", int'(pwm), 1);

    // R6: stop at zero, no reload
    wr(2'd2, ctrl(0, 0, 1, 0));
    chk("R6 run", int'(run), 0);
    ticks(3);
    chk("R6 cnt stays zero", int'(cnt), 0);
    chk("R6 no irq", int'(irq), 0);
    wr(2'd2, ctrl(1, 0, 1, 0));
    chk("R6 restart reload", int'(cnt), 2);
    ticks(1);
    wr(2'd2, ctrl(0, 0, 1, 0));
    ticks(3);
    chk("R6 stop mid count", int'(cnt), 1);
    wr(2'd2, ctrl(1, 0, 1, 0));
    chk("R6 restart mid", int'(cnt), 2);
    wr(2'd2, ctrl(0, 0, 1, 0));

    // R9: manual update while stopped, ignored while running
    wr(2'd0, 16'd7);
    wr(2'd1, 16'd7);
    wr(2'd2, ctrl(0, 1, 1, 0));
    chk("R9 update cnt", int'(cnt), 7);
    chk("R9 update pwm", int'(pwm), 1);
    chk("R9 update no run", int'(run), 0);
    wr(2'd2, ctrl(1, 0, 1, 0));
    ticks(2);
    chk("R9 running", int'(cnt), 5);
    wr(2'd0, 16'd4);
    wr(2'd2, ctrl(1, 1, 1, 0));
    chk("R9 update ignored", int'(cnt), 5);
    chk("R9 still running", int'(run), 1);
    wr(2'd2, ctrl(0, 0, 1, 0));

    // R8: one-shot
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd1);
    wr(2'd2, ctrl(1, 0, 0, 0));
    chk("R8 start", int'(cnt), 3);
    for (int k = 1; k <= 3; k++) begin
      ticks(1);
      chk("R8 count", int'(cnt), 3 - k);
      chk("R8 pwm", int'(pwm), (3 - k) <= 1 ? 1 : 0);
    end
    ticks(1);
    chk("R8 irq", int'(irq), 1);
    chk("R8 stopped", int'(run), 0);
    chk("R8 cnt zero", int'(cnt), 0);
    chk("R8 pwm low", int'(pwm), 0);
    ticks(2);
    chk("R8 no second irq", int'(irq), 0);
    chk("R8 cnt stays", int'(cnt), 0);
    wr(2'd2, ctrl(1, 0, 0, 0));
    chk("R8 restart", int'(cnt), 3);

    // R10: invert while stopped
    wr(2'd2, ctrl(0, 0, 0, 1));
    chk("R10 inverted idle", int'(pwm), 1);
    wr(2'd2, ctrl(0, 0, 0, 0));
    chk("R10 normal idle", int'(pwm), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule